// File: doc/BRIEF.md
# Cascadable LCD Segment Line Loader

This block gathers one display line of pixel codes for a row of 120 driver positions and then moves the whole line into an output latch in a single step. Pixel data comes in on a data clock. It arrives either four bits at a time on a nibble bus or one bit at a time on bit 0 of that bus. Three pixel formats are supported: two-level (1 bit per pixel), four-level (2 bits) and sixteen-level (4 bits). The line can be filled from position 0 upward or from position 119 downward.

Several loaders can be chained to drive a wider panel. Each one takes data only while its chain enable input is active. It counts the data it receives and stops on its own once its active segment field is full. It then sends a one-clock enable pulse to the next device in the chain. A configuration input reserves part of the positions for common lines, which shrinks the segment field. A rising edge on the latch pulse publishes the gathered line and re-arms the loader. Driving the display-off input low blanks the latched line.

Top module: `lcd_seg_loader`

## Requirements
- R1: While reset is applied, and after it is released, every line code is 0 and both chain outputs are high, until data is loaded and latched.
- R2: When `par_sel` is 1, data arrives on all four bits of `din`. When `par_sel` is 0, only `din[0]` carries data and `din[3:1]` has no effect on the stored codes.
- R3: Two-level format (`gray_mode` 00). In parallel mode each clock stores 4 pixels: `din[k]` goes to the k-th next position in fill order. In serial mode each clock stores one pixel. The code stored is 0 or 1.
- R4: Four-level format (`gray_mode` 01). In parallel mode each clock stores 2 pixels: `din[1:0]` is the earlier pixel and `din[3:2]` the later one, with the high bit as msb. In serial mode a pixel takes 2 clocks and its bits arrive lsb first.
- R5: Sixteen-level format (`gray_mode` 10). In parallel mode each clock stores one pixel, with `din[3]` as msb. In serial mode a pixel takes 4 clocks and its bits arrive lsb first.
- R6: With `dir_up` 1, the line fills from position 0 upward, the chain input is `chain_q_in_n` and the chain output is `chain_p_out_n`. With `dir_up` 0, the line fills from position 119 downward and the two chain pins swap roles. So in the two-level parallel format the first nibble puts `din[0]` at position 119 and `din[3]` at position 116.
- R7: The segment field size follows `cfg`: 0 gives 120, 1 gives 88, 2 gives 72, 3 gives 56, 4 gives 40, 5 gives 24, 6 gives 8, and 7 gives 0. Data arriving after the field is full is ignored.
- R8: With a field size S, the field covers positions 0..S-1 when filling upward and positions 119 down to 120-S when filling downward. Positions outside the field keep their stored codes.
- R9: No data is taken while the chain input selected for the current direction is high.
- R10: A rising edge of `latch_pulse` copies all gathered codes to `line_codes` on that clock and restarts the count. At any other time `line_codes` does not change, except through R12.
- R11: The clock that takes the last datum of the field drives the active chain output low for exactly one following clock period. The other chain output stays high.
- R12: On every clock with `disp_off_n` low, all line codes are cleared to 0 and a latch pulse does not load them. The gathered codes are kept, so a later latch publishes them.
- R13: `gray_mode` 11 behaves as the two-level format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| par_sel | input | 1 | 1 = nibble bus, 0 = serial on din[0] |
| dir_up | input | 1 | 1 = fill upward from position 0, 0 = fill downward from position 119 |
| gray_mode | input | 2 | 00 two-level, 01 four-level, 10 sixteen-level, 11 two-level |
| cfg | input | 3 | Common/segment split, selects the segment field size |
| din | input | 4 | Pixel data bus |
| latch_pulse | input | 1 | Rising edge publishes the line and re-arms the loader |
| disp_off_n | input | 1 | Active-low display off, clears the line codes |
| chain_p_in_n | input | 1 | Chain enable input on side P, used when filling downward |
| chain_q_in_n | input | 1 | Chain enable input on side Q, used when filling upward |
| chain_p_out_n | output | 1 | Chain enable output on side P, used when filling upward |
| chain_q_out_n | output | 1 | Chain enable output on side Q, used when filling downward |
| line_codes | output | 480 | Latched codes, position i at bits [4i+3:4i] |

## Verification
The checker watches four rules on every clock. At most one chain output is low at a time. Any low chain output lasts only one clock and follows an active chain input. Display-off clears the line on the next sample. The latched line never moves without a latch edge. What those properties cannot see is where each pixel lands and what it holds. That covers nibble splitting, serial lsb-first assembly, field size and position in mixed configurations, and direction reversal. The bench shows these by loading whole lines under each combination of format, bus, direction and configuration, and then comparing every position against its own model. It also confirms that the pulse arrives on the clock after the final datum.

// File: rtl/lcdseg_pkg.sv
package lcdseg_pkg;
  localparam int CODE_W = 4;
  typedef enum logic [1:0] {
    GM_BW  = 2'b00,
    GM_G4  = 2'b01,
    GM_G16 = 2'b10,
    GM_RSV = 2'b11
  } gray_e;
endpackage

// File: rtl/lcdseg_mode_dec.sv
module lcdseg_mode_dec
  import lcdseg_pkg::*;
#(
  parameter int NPOS     = 120,
  parameter int COM_STEP = 16,
  parameter int CFG_W    = 3,
  parameter int CNT_W    = $clog2(NPOS + 1)
) (
  input  logic             par_sel,
  input  logic [1:0]       gray_mode,
  input  logic [CFG_W-1:0] cfg,
  output logic [CNT_W-1:0] seg_cnt,
  output logic [1:0]       bpp_m1,
  output logic [2:0]       step
);
  logic [CNT_W-1:0] com_cnt;

  // Common lines reserved by the configuration; the segment field is the rest.
  always_comb begin
    if (cfg == '0)
      com_cnt = '0;
    else if (cfg == '1)
      com_cnt = CNT_W'(NPOS);
    else
      com_cnt = CNT_W'(COM_STEP) * (CNT_W'(cfg) + CNT_W'(1));
    seg_cnt = CNT_W'(NPOS) - com_cnt;
  end

  always_comb begin
    case (gray_e'(gray_mode))
      GM_G4:   begin bpp_m1 = 2'd1; step = par_sel ? 3'd2 : 3'd1; end
      GM_G16:  begin bpp_m1 = 2'd3; step = 3'd1; end
      default: begin bpp_m1 = 2'd0; step = par_sel ? 3'd4 : 3'd1; end
    endcase
  end
endmodule

// File: rtl/lcdseg_ctrl.sv
module lcdseg_ctrl
  import lcdseg_pkg::*;
#(
  parameter int NPOS  = 120,
  parameter int CNT_W = $clog2(NPOS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              par_sel,
  input  logic              dir_up,
  input  logic              din0,
  input  logic              latch_pulse,
  input  logic              chain_p_in_n,
  input  logic              chain_q_in_n,
  input  logic [CNT_W-1:0]  seg_cnt,
  input  logic [1:0]        bpp_m1,
  input  logic [2:0]        step,
  output logic              wr_en,
  output logic [CNT_W-1:0]  wr_base,
  output logic [CODE_W-1:0] ser_code,
  output logic              lp_rise,
  output logic              chain_p_out_n,
  output logic              chain_q_out_n
);
  logic [CNT_W-1:0]  pix_q, pix_d;
  logic [1:0]        sub_q, sub_d;
  logic [CODE_W-1:0] asm_q, asm_d;
  logic              lp_q, eo_q, eo_d;
  logic              en_act, full, take, pix_done, last;
  logic [CNT_W:0]    pix_sum;

  always_comb begin
    en_act   = dir_up ? ~chain_q_in_n : ~chain_p_in_n;
    full     = (pix_q >= seg_cnt);
    lp_rise  = latch_pulse & ~lp_q;
    take     = en_act & ~full & ~lp_rise;
    pix_done = par_sel | (sub_q == bpp_m1);
    wr_en    = take & pix_done;
    pix_sum  = {1'b0, pix_q} + (CNT_W+1)'(step);
    last     = wr_en & (pix_sum == {1'b0, seg_cnt});
    ser_code = asm_q | (CODE_W'(din0) << sub_q);
    wr_base  = pix_q;
  end

  always_comb begin
    pix_d = pix_q;
    sub_d = sub_q;
    asm_d = asm_q;
    eo_d  = last;
    if (lp_rise) begin
      pix_d = '0;
      sub_d = '0;
      asm_d = '0;
    end else if (take) begin
      if (pix_done) begin
        pix_d = pix_sum[CNT_W-1:0];
        sub_d = '0;
        asm_d = '0;
      end else begin
        sub_d        = sub_q + 2'd1;
        asm_d[sub_q] = din0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_q <= '0;
      sub_q <= '0;
      asm_q <= '0;
      lp_q  <= 1'b0;
      eo_q  <= 1'b0;
    end else begin
      pix_q <= pix_d;
      sub_q <= sub_d;
      asm_q <= asm_d;
      lp_q  <= latch_pulse;
      eo_q  <= eo_d;
    end
  end

  assign chain_p_out_n = ~(eo_q & dir_up);
  assign chain_q_out_n = ~(eo_q & ~dir_up);
endmodule

// File: rtl/lcdseg_bank.sv
module lcdseg_bank
  import lcdseg_pkg::*;
#(
  parameter int NPOS  = 120,
  parameter int CNT_W = $clog2(NPOS + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [CNT_W-1:0]         wr_base,
  input  logic [2:0]               wr_step,
  input  logic                     dir_up,
  input  logic                     par_sel,
  input  logic [1:0]               gray_mode,
  input  logic [3:0]               din,
  input  logic [CODE_W-1:0]        ser_code,
  input  logic                     lp_rise,
  input  logic                     disp_off_n,
  output logic [NPOS*CODE_W-1:0]   line_codes
);
  for (genvar gi = 0; gi < NPOS; gi++) begin : g_pos
    logic [CNT_W-1:0]  ofs;
    logic [CNT_W:0]    rel;
    logic              hit;
    logic [1:0]        k;
    logic [CODE_W-1:0] code, bank_q, bank_d, line_q, line_d;

    always_comb begin
      ofs = dir_up ? CNT_W'(gi) : CNT_W'(NPOS - 1 - gi);
      rel = {1'b0, ofs} - {1'b0, wr_base};
      hit = wr_en && (ofs >= wr_base) && (rel < (CNT_W+1)'(wr_step));
      k   = rel[1:0];
      if (!par_sel)
        code = ser_code;
      else begin
        case (gray_e'(gray_mode))
          GM_G4:   code = {2'b00, k[0] ? din[3:2] : din[1:0]};
          GM_G16:  code = din;
          default: code = {3'b000, din[k]};
        endcase
      end
      bank_d = hit ? code : bank_q;
      if (!disp_off_n)
        line_d = '0;
      else if (lp_rise)
        line_d = bank_q;
      else
        line_d = line_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bank_q <= '0;
        line_q <= '0;
      end else begin
        bank_q <= bank_d;
        line_q <= line_d;
      end
    end

    assign line_codes[gi*CODE_W +: CODE_W] = line_q;
  end
endmodule

// File: rtl/lcd_seg_loader.sv
module lcd_seg_loader
  import lcdseg_pkg::*;
#(
  parameter int NPOS     = 120,
  parameter int COM_STEP = 16,
  parameter int CFG_W    = 3,
  localparam int CNT_W   = $clog2(NPOS + 1),
  localparam int LINE_W  = NPOS * CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              par_sel,
  input  logic              dir_up,
  input  logic [1:0]        gray_mode,
  input  logic [CFG_W-1:0]  cfg,
  input  logic [3:0]        din,
  input  logic              latch_pulse,
  input  logic              disp_off_n,
  input  logic              chain_p_in_n,
  input  logic              chain_q_in_n,
  output logic              chain_p_out_n,
  output logic              chain_q_out_n,
  output logic [LINE_W-1:0] line_codes
);
  logic [1:0]        rst_sync;
  logic              rst_int_n;
  logic [CNT_W-1:0]  seg_cnt, wr_base;
  logic [1:0]        bpp_m1;
  logic [2:0]        step;
  logic              wr_en, lp_rise;
  logic [CODE_W-1:0] ser_code;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  lcdseg_mode_dec #(.NPOS(NPOS), .COM_STEP(COM_STEP), .CFG_W(CFG_W), .CNT_W(CNT_W)) u_dec (
    .par_sel(par_sel), .gray_mode(gray_mode), .cfg(cfg),
    .seg_cnt(seg_cnt), .bpp_m1(bpp_m1), .step(step)
  );

  lcdseg_ctrl #(.NPOS(NPOS), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_int_n), .par_sel(par_sel), .dir_up(dir_up),
    .din0(din[0]), .latch_pulse(latch_pulse),
    .chain_p_in_n(chain_p_in_n), .chain_q_in_n(chain_q_in_n),
    .seg_cnt(seg_cnt), .bpp_m1(bpp_m1), .step(step),
    .wr_en(wr_en), .wr_base(wr_base), .ser_code(ser_code), .lp_rise(lp_rise),
    .chain_p_out_n(chain_p_out_n), .chain_q_out_n(chain_q_out_n)
  );

  lcdseg_bank #(.NPOS(NPOS), .CNT_W(CNT_W)) u_bank (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .wr_base(wr_base),
    .wr_step(step), .dir_up(dir_up), .par_sel(par_sel), .gray_mode(gray_mode),
    .din(din), .ser_code(ser_code), .lp_rise(lp_rise), .disp_off_n(disp_off_n),
    .line_codes(line_codes)
  );
endmodule

// File: rtl/lcdseg_chk.sv
module lcdseg_chk #(
  parameter int LINE_W = 480
) (
  input logic              clk,
  input logic              rst_n,
  input logic              latch_pulse,
  input logic              disp_off_n,
  input logic              chain_p_in_n,
  input logic              chain_q_in_n,
  input logic              chain_p_out_n,
  input logic              chain_q_out_n,
  input logic [LINE_W-1:0] line_codes
);
  logic lp_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lp_seen <= 1'b0;
    else        lp_seen <= latch_pulse;
  end

  // R11: never both chain outputs low
  a_r11_one_side: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({~chain_p_out_n, ~chain_q_out_n}));

  // R11: a low chain output lasts a single clock
  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (!chain_p_out_n || !chain_q_out_n) |=> (chain_p_out_n && chain_q_out_n));

  // R9: a pulse out needs an active chain input on the clock before
  a_r9_out_needs_in: assert property (@(posedge clk) disable iff (!rst_n)
    (!chain_p_out_n || !chain_q_out_n) |-> $past(!chain_p_in_n || !chain_q_in_n));

  // R12: display off clears the latched line
  a_r12_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_off_n |=> (line_codes == '0));

  // R10: without a latch edge the line holds
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_off_n && !(latch_pulse && !lp_seen)) |=> $stable(line_codes));
endmodule

bind lcd_seg_loader lcdseg_chk #(.LINE_W(LINE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .latch_pulse(latch_pulse), .disp_off_n(disp_off_n),
  .chain_p_in_n(chain_p_in_n), .chain_q_in_n(chain_q_in_n),
  .chain_p_out_n(chain_p_out_n), .chain_q_out_n(chain_q_out_n),
  .line_codes(line_codes)
);

// File: tb/sim_lcd_seg_loader.sv
`timescale 1ns/1ps
module sim_lcd_seg_loader;
  localparam int NPOS = 120;
  localparam int NV   = 13;
  // {par_sel, gray_mode[1:0], dir_up, cfg[2:0]}
  localparam logic [6:0] VEC [NV] = '{
    7'b1_00_1_000, 7'b0_00_1_000, 7'b1_01_1_000, 7'b0_01_0_000,
    7'b1_10_0_000, 7'b0_10_1_001, 7'b1_00_0_001, 7'b1_01_0_011,
    7'b0_00_1_110, 7'b1_10_1_101, 7'b1_00_1_111, 7'b1_11_0_010,
    7'b0_10_0_000
  };

  logic clk = 1'b0;
  logic rst_n, par_sel, dir_up, latch_pulse, disp_off_n;
  logic chain_p_in_n, chain_q_in_n, chain_p_out_n, chain_q_out_n;
  logic [1:0] gray_mode;
  logic [2:0] cfg;
  logic [3:0] din;
  logic [NPOS*4-1:0] line_codes;
  logic [3:0] exp_bank [NPOS];
  logic [3:0] exp_line [NPOS];
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  lcd_seg_loader u0 (
    .clk(clk), .rst_n(rst_n), .par_sel(par_sel), .dir_up(dir_up),
    .gray_mode(gray_mode), .cfg(cfg), .din(din), .latch_pulse(latch_pulse),
    .disp_off_n(disp_off_n), .chain_p_in_n(chain_p_in_n), .chain_q_in_n(chain_q_in_n),
    .chain_p_out_n(chain_p_out_n), .chain_q_out_n(chain_q_out_n), .line_codes(line_codes)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic int segn(input logic [2:0] c);
    case (c)
      3'd0: return 120; 3'd1: return 88; 3'd2: return 72; 3'd3: return 56;
      3'd4: return 40;  3'd5: return 24; 3'd6: return 8;  default: return 0;
    endcase
  endfunction

  function automatic int bits_pp(input logic [1:0] g);
    return (g == 2'b01) ? 2 : (g == 2'b10) ? 4 : 1;
  endfunction

  function automatic logic [3:0] pv(input int seed, input int k, input int bpp);
    int v;
    v = seed * 5 + k * 3 + (k >> 3);
    return 4'(v & ((1 << bpp) - 1));
  endfunction

  // compare every position of line_codes against the model line
  task automatic cmp_line(input string req, input string what);
    int nbad = 0, fpos = 0, fa = 0, fe = 0;
    for (int i = 0; i < NPOS; i++)
      if (line_codes[4*i +: 4] !== exp_line[i]) begin
        if (nbad == 0) begin fpos = i; fa = int'(line_codes[4*i +: 4]); fe = int'(exp_line[i]); end
        nbad++;
      end
    chk(nbad == 0, req, $sformatf("%s pos %0d", what, fpos), fa, fe);
  endtask

  task automatic do_latch();
    @(negedge clk); latch_pulse = 1'b1;
    @(posedge clk); #1;
    if (disp_off_n) for (int i = 0; i < NPOS; i++) exp_line[i] = exp_bank[i];
    else for (int i = 0; i < NPOS; i++) exp_line[i] = 4'd0;
    @(negedge clk); latch_pulse = 1'b0;
  endtask

  task automatic run_line(input logic [6:0] v, input int seed);
    int s, bpp, ppc, nclk, np, nq, at, pix, b;
    logic [3:0] val;
    par_sel = v[6]; gray_mode = v[5:4]; dir_up = v[3]; cfg = v[2:0];
    s = segn(cfg); bpp = bits_pp(gray_mode);
    ppc = par_sel ? 4 / bpp : 1;
    nclk = par_sel ? s / ppc : s * bpp;
    np = 0; nq = 0; at = -1;
    for (int c = 0; c < nclk + 3; c++) begin
      @(negedge clk);
      chain_q_in_n = ~dir_up;
      chain_p_in_n = dir_up;
      din = 4'hF;
      if (c < nclk) begin
        if (par_sel) begin
          for (int j = 0; j < ppc; j++) begin
            pix = c * ppc + j;
            val = pv(seed, pix, bpp);
            if (bpp == 1) din[j] = val[0];
            else if (bpp == 2) din[2*j +: 2] = val[1:0];
            else din = val;
            exp_bank[dir_up ? pix : NPOS - 1 - pix] = val;
          end
        end else begin
          pix = c / bpp; b = c % bpp;
          val = pv(seed, pix, bpp);
          din = {3'b101, val[b]};   // R2: junk on din[3:1]
          if (b == bpp - 1) exp_bank[dir_up ? pix : NPOS - 1 - pix] = val;
        end
      end
      @(posedge clk); #1;
      if (!chain_p_out_n) begin np++; at = c; end
      if (!chain_q_out_n) begin nq++; at = c; end
    end
    // R11: one pulse on the active side, the clock after the last datum
    chk((dir_up ? np : nq) == (s > 0 ? 1 : 0), "R11", $sformatf("vec %0d pulses", seed),
        dir_up ? np : nq, s > 0 ? 1 : 0);
    chk((dir_up ? nq : np) == 0, "R11", $sformatf("vec %0d idle side", seed), dir_up ? nq : np, 0);
    chk(at == (s > 0 ? nclk - 1 : -1), "R11", $sformatf("vec %0d pulse clock", seed), at, s > 0 ? nclk - 1 : -1);
    // R10: line unchanged before the latch edge
    cmp_line("R10", $sformatf("vec %0d before latch", seed));
    @(negedge clk); chain_q_in_n = 1'b1; chain_p_in_n = 1'b1;
    do_latch();
    // R3 R4 R5 R6 R7 R8 R13 per vector
    cmp_line("R3/R4/R5/R6/R7/R8/R13", $sformatf("vec %0d line", seed));
  endtask

  initial begin
    #(200000 * 20);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NPOS; i++) begin exp_bank[i] = 4'd0; exp_line[i] = 4'd0; end
    rst_n = 1'b0; par_sel = 1'b1; dir_up = 1'b1; gray_mode = 2'b00; cfg = 3'd0;
    din = 4'h0; latch_pulse = 1'b0; disp_off_n = 1'b1;
    chain_p_in_n = 1'b1; chain_q_in_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    cmp_line("R1", "in reset");
    chk(chain_p_out_n && chain_q_out_n, "R1", "chain outs in reset",
        int'({chain_p_out_n, chain_q_out_n}), 3);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    cmp_line("R1", "after release");

    // R9: chain input inactive, data must be dropped
    for (int c = 0; c < 10; c++) begin
      @(negedge clk); din = 4'hF; chain_q_in_n = 1'b1; chain_p_in_n = 1'b0;
      @(posedge clk);
    end
    @(negedge clk); chain_p_in_n = 1'b1;
    do_latch();
    cmp_line("R9", "inactive chain input");

    for (int n = 0; n < NV; n++) run_line(VEC[n], n);

    // R12: display off clears line, latch while off stays cleared
    @(negedge clk); disp_off_n = 1'b0;
    @(posedge clk); #1;
    for (int i = 0; i < NPOS; i++) exp_line[i] = 4'd0;
    cmp_line("R12", "display off");
    do_latch();
    cmp_line("R12", "latch during off");
    @(negedge clk); disp_off_n = 1'b1;
    do_latch();
    cmp_line("R12", "gathered codes kept");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule